// File: doc/BRIEF.md
# Processor performance monitor unit

This unit counts events for a processor core. It has three counters that share one control word: a dedicated cycle counter and two programmable event counters. A one-cycle pulse vector from the core carries the countable events. Each event counter picks its source with an 8-bit selector. Code 0xFF counts every clock. Code 0x20 follows an external trace-output line, and that line stays quiet unless something drives it. Codes below `NUM_EVT` pick a bit of the event vector. All other codes never count.

The event counters have no enable of their own. Software parks an event counter by selecting code 0x20 with the trace line idle. One global enable bit starts and stops all three counters together. When a counter wraps, it sets a sticky overflow flag. Software clears a flag by writing a one to it. Each flag can raise one shared level interrupt through its own enable bit. The read/write port reaches the control word and each counter. The read port is combinational, and writes take effect at the next clock edge.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every counter reads 0, the control word reads 0 and `irq_o` is low.
- R2: While control bit 0 (global enable) is clear, no counter changes except through a direct write or a reset bit.
- R3: Address 1 is the cycle counter. While enabled with control bit 3 clear, it adds 1 on every clock. With bit 3 set, it adds 1 on every 64th clock, counted from the last cycle-reset or from reset.
- R4: Addresses 2 and 3 are event counters A and B. Their selectors are control bits 27:20 and 19:12. A selected code adds 1 per clock in which its source is high. Code 0xFF counts every clock, code 0x20 follows `trace_ext_i`, a code below `NUM_EVT` follows `evt_i[code]`, and any other code never counts.
- R5: A counter at 0xFFFFFFFF that advances reads 0 next and sets its flag. The flags are control bit 8 (A), bit 9 (B) and bit 10 (cycle).
- R6: Writing the control word with 1 in a flag bit clears that flag, and writing 0 leaves it alone. If the counter wraps in the same clock as the clearing write, the flag stays set.
- R7: Writing the control word with bit 1 set zeroes both event counters, and with bit 2 set it zeroes the cycle counter and the 64-clock divider. Bits 2:1 always read 0.
- R8: `irq_o` is high exactly while some flag is set together with its enable. The enables are bit 4 (A), bit 5 (B) and bit 6 (cycle).
- R9: Writing address 1, 2 or 3 loads that counter at the next edge, and the load wins over a count in that clock.
- R10: Writing back a control value that was read changes only the flags it clears. A control write cannot set a flag. Bits 31:28, 11 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 2 | 0 control, 1 cycle counter, 2 event counter A, 3 event counter B |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| evt_i | input | NUM_EVT | One-cycle event pulses from the core |
| trace_ext_i | input | 1 | External trace-output line, event code 0x20 |
| irq_o | output | 1 | Shared overflow interrupt level |

## Verification
All state changes land at the clock edge that samples the write or the event pulse. The combinational read path shows the new value from that edge onward. The interrupt follows the flag at the same edge, because it is a function of registers only. The bench drives each stimulus half a cycle before an edge and steps its own model just after that edge. It then compares every readable value and the interrupt at the following falling edge, exactly one edge after the stimulus. The divider case is checked at the 63rd and 64th edges after the cycle reset. The same-clock wrap-and-clear case is lined up by loading the cycle counter three edges before the control write.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned SEL_W   = 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned NUM_CTR = 3;

  // register port addresses
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CYC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_EVA  = 2'd2;

  // control word fields
  localparam int unsigned B_EN      = 0;
  localparam int unsigned B_RST_EV  = 1;
  localparam int unsigned B_RST_CYC = 2;
  localparam int unsigned B_DIV     = 3;
  localparam int unsigned B_IEN_LO  = 4;
  localparam int unsigned B_FLAG_LO = 8;
  localparam int unsigned B_SELB_LO = 12;
  localparam int unsigned B_SELA_LO = 20;

  // flag / enable lane order: A, B, cycle
  localparam int unsigned LANE_CYC = 2;

  localparam logic [SEL_W-1:0] CODE_TRACE  = 8'h20;
  localparam logic [SEL_W-1:0] CODE_CYCLES = 8'hFF;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = ld_i | clr_i | inc_i;
    wrap_o = inc_i & ~ld_i & ~clr_i & (&cnt_q);
    if (ld_i)       cnt_d = ld_val_i;
    else if (clr_i) cnt_d = '0;
    else            cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler #(
  parameter int unsigned LOG2 = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  logic [LOG2-1:0] pre_q, pre_d;
  logic            pre_en;

  always_comb begin
    pre_en = run_i | clr_i;
    pre_d  = clr_i ? '0 : pre_q + LOG2'(1);
    tick_o = run_i & (&pre_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end
endmodule

// File: rtl/pmu_evt_match.sv
module pmu_evt_match #(
  parameter int unsigned NUM_EVT = 32,
  parameter int unsigned SEL_W   = 8
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               trace_i,
  output logic               hit_o
);
  localparam int unsigned IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam logic [SEL_W-1:0] LIMIT = SEL_W'(NUM_EVT);

  always_comb begin
    if (sel_i == pmu_pkg::CODE_CYCLES)     hit_o = 1'b1;
    else if (sel_i == pmu_pkg::CODE_TRACE) hit_o = trace_i;
    else if (sel_i < LIMIT)                hit_o = evt_i[sel_i[IDX_W-1:0]];
    else                                   hit_o = 1'b0;
  end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned NUM_EVT    = 32,
  parameter int unsigned PRESC_LOG2 = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_we_i,
  input  logic [pmu_pkg::ADDR_W-1:0]    reg_addr_i,
  input  logic [pmu_pkg::REG_W-1:0]     reg_wdata_i,
  output logic [pmu_pkg::REG_W-1:0]     reg_rdata_o,
  input  logic [NUM_EVT-1:0]            evt_i,
  input  logic                          trace_ext_i,
  output logic                          irq_o
);
  import pmu_pkg::*;

  localparam int unsigned NUM_EV_CTR = NUM_CTR - 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // control word state
  logic                 en_q, en_d;
  logic                 div_q, div_d;
  logic [NUM_CTR-1:0]   ien_q, ien_d;
  logic [NUM_CTR-1:0]   flag_q, flag_d;
  logic [SEL_W-1:0]     sel_q [NUM_EV_CTR];
  logic [SEL_W-1:0]     sel_d [NUM_EV_CTR];
  logic                 ctrl_wr;
  logic [NUM_CTR-1:0]   wrap;
  logic [NUM_CTR-1:0]   flag_clr;
  logic [CNT_W-1:0]     cnt [NUM_CTR];

  assign ctrl_wr = reg_we_i & (reg_addr_i == ADDR_CTRL);

  always_comb begin
    en_d     = reg_wdata_i[B_EN];
    div_d    = reg_wdata_i[B_DIV];
    ien_d    = reg_wdata_i[B_IEN_LO +: NUM_CTR];
    sel_d[0] = reg_wdata_i[B_SELA_LO +: SEL_W];
    sel_d[1] = reg_wdata_i[B_SELB_LO +: SEL_W];
    flag_clr = ctrl_wr ? reg_wdata_i[B_FLAG_LO +: NUM_CTR] : '0;
    flag_d   = (flag_q & ~flag_clr) | wrap;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= 1'b0;
      ien_q <= '0;
      for (int i = 0; i < int'(NUM_EV_CTR); i++) sel_q[i] <= '0;
    end else if (ctrl_wr) begin
      en_q  <= en_d;
      div_q <= div_d;
      ien_q <= ien_d;
      for (int i = 0; i < int'(NUM_EV_CTR); i++) sel_q[i] <= sel_d[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  // event counters, lanes 0 (A) and 1 (B)
  for (genvar k = 0; k < int'(NUM_EV_CTR); k++) begin : g_ev
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(ADDR_EVA) + k);
    logic hit;

    pmu_evt_match #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_match (
      .sel_i   (sel_q[k]),
      .evt_i   (evt_i),
      .trace_i (trace_ext_i),
      .hit_o   (hit)
    );

    pmu_counter #(.W(CNT_W)) u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_n),
      .ld_i     (reg_we_i & (reg_addr_i == MY_ADDR)),
      .ld_val_i (reg_wdata_i[CNT_W-1:0]),
      .clr_i    (ctrl_wr & reg_wdata_i[B_RST_EV]),
      .inc_i    (en_q & hit),
      .cnt_o    (cnt[k]),
      .wrap_o   (wrap[k])
    );
  end

  // cycle counter, lane 2
  logic presc_tick;
  logic cyc_clr;
  assign cyc_clr = ctrl_wr & reg_wdata_i[B_RST_CYC];

  pmu_prescaler #(.LOG2(PRESC_LOG2)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (en_q),
    .clr_i  (cyc_clr),
    .tick_o (presc_tick)
  );

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .ld_i     (reg_we_i & (reg_addr_i == ADDR_CYC)),
    .ld_val_i (reg_wdata_i[CNT_W-1:0]),
    .clr_i    (cyc_clr),
    .inc_i    (en_q & (~div_q | presc_tick)),
    .cnt_o    (cnt[LANE_CYC]),
    .wrap_o   (wrap[LANE_CYC])
  );

  assign irq_o = |(flag_q & ien_q);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_CTRL: begin
        reg_rdata_o[B_EN]                      = en_q;
        reg_rdata_o[B_DIV]                     = div_q;
        reg_rdata_o[B_IEN_LO +: NUM_CTR]       = ien_q;
        reg_rdata_o[B_FLAG_LO +: NUM_CTR]      = flag_q;
        reg_rdata_o[B_SELA_LO +: SEL_W]        = sel_q[0];
        reg_rdata_o[B_SELB_LO +: SEL_W]        = sel_q[1];
      end
      ADDR_CYC: reg_rdata_o = REG_W'(cnt[LANE_CYC]);
      ADDR_EVA: reg_rdata_o = REG_W'(cnt[0]);
      default:  reg_rdata_o = REG_W'(cnt[1]);
    endcase
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [31:0]      reg_wdata_i,
  input logic             irq_o,
  input logic             en_q,
  input logic             div_q,
  input logic [2:0]       flag_q,
  input logic [2:0]       wrap,
  input logic [CNT_W-1:0] cnt_a,
  input logic [CNT_W-1:0] cnt_b,
  input logic [CNT_W-1:0] cnt_cyc
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we_i && (reg_addr_i == 2'd0);

  p_hold_off_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!en_q && !reg_we_i) |=> ($stable(cnt_a) && $stable(cnt_b) && $stable(cnt_cyc)));

  p_cyc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_q && !div_q && !reg_we_i) |=> (cnt_cyc == $past(cnt_cyc) + CNT_W'(1)));

  p_wrap_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    wrap[2] |=> (cnt_cyc == '0));

  p_wrap_zero_a_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    wrap[0] |=> (cnt_a == '0));

  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|wrap) |=> ((flag_q & $past(wrap)) == $past(wrap)));

  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((|flag_q) && !ctrl_wr) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  p_cyc_reset_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ctrl_wr && reg_wdata_i[2]) |=> (cnt_cyc == '0));

  p_irq_src_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (|flag_q));

  p_load_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_we_i && reg_addr_i == 2'd1) |=> (cnt_cyc == $past(reg_wdata_i[CNT_W-1:0])));
endmodule

bind perf_mon_unit pmu_checker #(.CNT_W(CNT_W)) u_pmu_checker (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .en_q        (en_q),
  .div_q       (div_q),
  .flag_q      (flag_q),
  .wrap        (wrap),
  .cnt_a       (cnt[0]),
  .cnt_b       (cnt[1]),
  .cnt_cyc     (cnt[2])
);

// File: tb/test_perf_mon_unit.sv
module test_perf_mon_unit;
  localparam int CLK_P   = 10;
  localparam int NUM_EVT = 32;

  localparam logic [31:0] EN      = 32'h1;
  localparam logic [31:0] RST_EV  = 32'h2;
  localparam logic [31:0] RST_CYC = 32'h4;
  localparam logic [31:0] DIV     = 32'h8;
  localparam logic [31:0] IEN_A   = 32'h10;
  localparam logic [31:0] IEN_CYC = 32'h40;
  localparam logic [31:0] FL_A    = 32'h100;
  localparam logic [31:0] FL_B    = 32'h200;
  localparam logic [31:0] FL_CYC  = 32'h400;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               we;
  logic [1:0]         addr;
  logic [31:0]        wdata;
  logic [31:0]        rdata;
  logic [NUM_EVT-1:0] evt;
  logic               trace;
  logic               irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  perf_mon_unit #(.CNT_W(32), .NUM_EVT(NUM_EVT), .PRESC_LOG2(6)) i_perf_mon_unit (
    .clk_i (clk), .rst_ni (rst_n), .reg_we_i (we), .reg_addr_i (addr),
    .reg_wdata_i (wdata), .reg_rdata_o (rdata), .evt_i (evt),
    .trace_ext_i (trace), .irq_o (irq)
  );

  // behavioural reference model: counters [0]=cycle [1]=A [2]=B,
  // flag/enable lanes [0]=A [1]=B [2]=cycle
  logic [31:0] m_cnt [3];
  bit          m_en, m_div;
  logic [2:0]  m_ien, m_flag;
  logic [7:0]  m_sela, m_selb;
  int          m_pre;

  function automatic bit m_hit(logic [7:0] s);
    if (s == 8'hFF) return 1'b1;
    if (s == 8'h20) return trace;
    if (s < 8'(NUM_EVT)) return evt[s[4:0]];
    return 1'b0;
  endfunction

  function automatic logic [31:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return {4'b0, m_sela, m_selb, 1'b0, m_flag, 1'b0, m_ien, m_div, 2'b0, m_en};
      2'd1: return m_cnt[0];
      2'd2: return m_cnt[1];
      default: return m_cnt[2];
    endcase
  endfunction

  task automatic m_step();
    bit         wc = we && addr == 2'd0;
    bit [2:0]   inc;
    logic [2:0] ovf = 3'b000;
    inc[0] = m_en && (!m_div || m_pre == 63);
    inc[1] = m_en && m_hit(m_sela);
    inc[2] = m_en && m_hit(m_selb);
    for (int i = 0; i < 3; i++) begin
      bit rst_bit = (i == 0) ? (wc && wdata[2]) : (wc && wdata[1]);
      int lane = (i == 0) ? 2 : i - 1;
      if (we && addr == 2'(i + 1)) m_cnt[i] = wdata;
      else if (rst_bit) m_cnt[i] = 0;
      else if (inc[i]) begin
        if (m_cnt[i] == 32'hFFFF_FFFF) ovf[lane] = 1'b1;
        m_cnt[i] = m_cnt[i] + 1;
      end
    end
    if (wc && wdata[2]) m_pre = 0;
    else if (m_en) m_pre = (m_pre + 1) % 64;
    m_flag = (m_flag & ~(wc ? wdata[10:8] : 3'b000)) | ovf;
    if (wc) begin
      m_en = wdata[0]; m_div = wdata[3]; m_ien = wdata[6:4];
      m_sela = wdata[27:20]; m_selb = wdata[19:12];
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: model steps after the edge, compare at the falling edge
  task automatic cyc();
    @(posedge clk);
    m_step();
    @(negedge clk);
    chk("R8", {31'b0, irq}, {31'b0, |(m_flag & m_ien)});
    case (addr)
      2'd0: chk("R10", rdata, m_read(addr));
      2'd1: chk("R3", rdata, m_read(addr));
      default: chk("R4", rdata, m_read(addr));
    endcase
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    cyc();
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string req);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  function automatic logic [31:0] sa(logic [7:0] c); return {4'b0, c, 20'b0}; endfunction
  function automatic logic [31:0] sb(logic [7:0] c); return {12'b0, c, 12'b0}; endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; we = 1'b0; addr = 2'd0; wdata = '0; evt = '0; trace = 1'b0;
    for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    m_en = 0; m_div = 0; m_ien = 0; m_flag = 0; m_sela = 0; m_selb = 0; m_pre = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) rd(2'(a), 32'h0, "R1");
    chk("R1", {31'b0, irq}, 32'h0);

    // R9 loads, R2 hold while disabled
    wr(2'd2, 32'h10); wr(2'd3, 32'h20); wr(2'd1, 32'h30);
    evt = '1; trace = 1'b1;
    repeat (5) cyc();
    evt = '0; trace = 1'b0;
    rd(2'd1, 32'h30, "R2"); rd(2'd2, 32'h10, "R9"); rd(2'd3, 32'h20, "R9");

    // R4 vector code on A, parked trace code on B; R3 cycle count
    wr(2'd0, EN | sa(8'h05) | sb(8'h20));
    for (int i = 0; i < 6; i++) begin
      evt[5] = (i % 2 == 0);
      cyc();
    end
    evt = '0;
    rd(2'd2, 32'h13, "R4"); rd(2'd3, 32'h20, "R4"); rd(2'd1, 32'h36, "R3");

    // R4 trace line, all-cycles code, out-of-range code
    trace = 1'b1;
    repeat (4) cyc();
    trace = 1'b0;
    rd(2'd3, 32'h24, "R4");
    wr(2'd0, EN | sa(8'hFF) | sb(8'h40));
    evt = '1;
    repeat (3) cyc();
    evt = '0;
    rd(2'd2, 32'h16, "R4"); rd(2'd3, 32'h24, "R4");

    // R5 wrap of counter A, R8 interrupt, R6 clear, R10 write-back
    wr(2'd0, EN | IEN_A | sa(8'h07) | sb(8'h40));
    wr(2'd2, 32'hFFFF_FFFF);
    evt[7] = 1'b1; cyc(); evt = '0;
    rd(2'd2, 32'h0, "R5");
    rd(2'd0, EN | IEN_A | FL_A | sa(8'h07) | sb(8'h40), "R5");
    chk("R8", {31'b0, irq}, 32'h1);
    wr(2'd0, EN | sa(8'h07) | sb(8'h40));
    rd(2'd0, EN | FL_A | sa(8'h07) | sb(8'h40), "R6");
    chk("R8", {31'b0, irq}, 32'h0);
    wr(2'd0, EN | IEN_A | sa(8'h07) | sb(8'h40));
    chk("R8", {31'b0, irq}, 32'h1);
    rd(2'd0, EN | IEN_A | FL_A | sa(8'h07) | sb(8'h40), "R10");
    v = rdata;
    wr(2'd0, v);
    rd(2'd0, v & ~FL_A, "R10");
    chk("R6", {31'b0, irq}, 32'h0);
    wr(2'd0, EN | FL_B | sa(8'h07) | sb(8'h40));
    rd(2'd0, EN | sa(8'h07) | sb(8'h40), "R10");

    // R5 cycle wrap, R6 wrap in the same clock as the clearing write
    v = EN | IEN_CYC | sa(8'h07) | sb(8'h40);
    wr(2'd0, v);
    wr(2'd1, 32'hFFFF_FFFE);
    cyc(); cyc();
    rd(2'd0, v | FL_CYC, "R5");
    chk("R8", {31'b0, irq}, 32'h1);
    wr(2'd1, 32'hFFFF_FFFD);
    cyc(); cyc();
    wr(2'd0, v | FL_CYC);
    rd(2'd0, v | FL_CYC, "R6");
    rd(2'd1, 32'h0, "R5");
    wr(2'd0, v | FL_CYC);
    rd(2'd0, v, "R6");

    // R7 cycle reset, R3 divide-by-64
    wr(2'd0, EN | DIV | RST_CYC | sa(8'h07) | sb(8'h40));
    rd(2'd0, EN | DIV | sa(8'h07) | sb(8'h40), "R7");
    rd(2'd1, 32'h0, "R7");
    repeat (63) cyc();
    rd(2'd1, 32'h0, "R3");
    cyc();
    rd(2'd1, 32'h1, "R3");

    // R7 event reset, then R2 hold after disabling
    wr(2'd0, EN | RST_EV | sa(8'hFF) | sb(8'hFF));
    rd(2'd2, 32'h0, "R7"); rd(2'd3, 32'h0, "R7");
    wr(2'd0, 32'h0);
    evt = '1; trace = 1'b1;
    repeat (5) cyc();
    evt = '0; trace = 1'b0;
    rd(2'd2, 32'h1, "R2"); rd(2'd3, 32'h1, "R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule